// File: doc/BRIEF.md
# Serial NAND Program and Erase Sequencer

This block drives the write-type command sequences of a serial NAND flash device through a byte-level SPI master port. A single engine runs one of two operations. A page program loads a stream of bytes into the device cache at a 16-bit column, commits it to a 24-bit row address, and then polls the device until it is ready. A block erase sends a 16-bit block number and polls the same way. Both operations begin with a write-enable command. Both end with a check of the status byte.

A start pulse latches the operation select, the addresses, the data length and the on-die ECC select. Data bytes are fetched one at a time: `data_next` pulses once per byte consumed, and `data_in` must present the next byte until then. Each SPI byte is issued as a one-cycle `xfer_req` with the byte and an end-of-frame flag. The master answers with a one-cycle `xfer_ack` carrying the received byte. The master deasserts chip select after a byte flagged as the last of its frame.

Completion is reported with a one-cycle `done` pulse. A failure or a poll timeout leaves a sticky error flag, which software clears with `err_clr`. While any flag is set, new starts are refused.

Top module: `nand_pe_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `xfer_req`, `data_next` and all three error flags are 0.
- R2: A program sends, as separate frames: write enable 0x06; then 0x02, column high, column low and the `data_len` data bytes in stream order; then 0x10 and the row address as three bytes, most significant first; then status polls. `xfer_last` is set only on the final byte of each frame.
- R3: An erase sends write enable 0x06, then the frame 0xD8, 0x00, block high, block low, then status polls.
- R4: A status poll is the frame 0x0F, 0xC0, 0x00, and its third byte returns the status. Polling repeats while status bit 0 is 1, and stops at the first reply with bit 0 clear. Other status bits are ignored while bit 0 is 1.
- R5: On a completed program, status bit 3 set raises `err_prog`. On a completed erase, status bit 2 set raises `err_erase`. The other operation's bit has no effect, and at most one error flag is ever set.
- R6: If `PROG_POLL_MAX` program polls or `ERASE_POLL_MAX` erase polls all reply busy, the block raises `err_tmo`, pulses `done` and goes idle. No further frames are sent, and the ECC feature bit is not restored.
- R7: With the ECC select latched at 1, the block first reads feature register 0xB0 (0x0F, 0xB0, 0x00) and writes it back with bit 4 set (0x1F, 0xB0, value|0x10), ahead of the write enable. After a successful poll it reads 0xB0 again and writes it back with bit 4 cleared. All other feature bits are preserved.
- R8: Each accepted operation ends with exactly one single-cycle `done` pulse, during which `busy` is 0.
- R9: `start` is ignored while `busy` is 1 or while any error flag is set. Inputs other than `data_in` are not sampled after the start is accepted. `err_clr` clears all error flags, which otherwise hold.
- R10: `data_next` pulses exactly `data_len` times per program, each time together with the `xfer_req` that carries that data byte, and never during an erase.
- R11: `xfer_req` is a single-cycle pulse. No new request is issued until `xfer_ack` answers the previous one, and none is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for one operation |
| op_erase | input | 1 | 1 selects block erase, 0 selects page program |
| ecc_en | input | 1 | Set the on-die ECC feature bit around the operation |
| row_addr | input | 24 | Page row address for program |
| col_addr | input | 16 | Column of the first data byte |
| blk_addr | input | 16 | Block number for erase |
| data_len | input | $clog2(MAX_BYTES+1) | Number of data bytes to load |
| data_in | input | 8 | Current data byte of the stream |
| data_next | output | 1 | Pulse: data_in consumed, present the next byte |
| err_clr | input | 1 | Clear sticky error flags |
| xfer_req | output | 1 | Pulse: transfer one SPI byte |
| xfer_byte | output | 8 | Byte to send |
| xfer_last | output | 1 | This byte ends the frame (release chip select) |
| xfer_ack | input | 1 | Pulse: byte transfer finished |
| xfer_rx | input | 8 | Byte received during the acknowledged transfer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse: operation ended |
| err_prog | output | 1 | Sticky program-fail flag |
| err_erase | output | 1 | Sticky erase-fail flag |
| err_tmo | output | 1 | Sticky poll-timeout flag |

## Verification
The hardest states to reach are the poll-budget edges. A timeout needs every reply for the whole budget to be busy. The budget boundary needs exactly one fewer busy reply before a ready one. ECC restoration also has to be shown skipped on the timeout path. The bench shrinks both budgets to a handful of polls. Its device model answers each status poll from a per-operation busy countdown, and its busy replies carry the fail bits so that a premature fail check would show. The model keeps a live feature register, so that the read-modify-write of bit 4 can be checked against the value left at the end.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_FRD, PH_FSET, PH_WREN, PH_LOAD, PH_EXEC,
    PH_ERASE, PH_POLL, PH_FRD2, PH_FCLR, PH_DONE
  } phase_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_LOAD  = 8'h02;
  localparam logic [7:0] OP_EXEC  = 8'h10;
  localparam logic [7:0] OP_ERASE = 8'hD8;
  localparam logic [7:0] OP_GETF  = 8'h0F;
  localparam logic [7:0] OP_SETF  = 8'h1F;
  localparam logic [7:0] REG_STAT = 8'hC0;
  localparam logic [7:0] REG_FEAT = 8'hB0;
  localparam logic [7:0] ECC_MASK = 8'h10;

  localparam int ST_BUSY  = 0;
  localparam int ST_EFAIL = 2;
  localparam int ST_PFAIL = 3;

endpackage

// File: rtl/nand_frame_byte.sv
module nand_frame_byte
  import nand_seq_pkg::*;
#(
  parameter int KW = 13,
  parameter int LW = 13
) (
  input  phase_t          phase,
  input  logic [KW-1:0]   idx,
  input  logic [23:0]     row,
  input  logic [15:0]     col,
  input  logic [15:0]     blk,
  input  logic [7:0]      feat,
  input  logic [7:0]      data_in,
  input  logic [LW-1:0]   dlen,
  output logic [7:0]      tx,
  output logic [KW-1:0]   flen,
  output logic            is_data
);

  always_comb begin
    tx      = 8'h00;
    flen    = KW'(1);
    is_data = 1'b0;
    case (phase)
      PH_FRD, PH_FRD2, PH_POLL: begin
        flen = KW'(3);
        case (idx[1:0])
          2'd0:    tx = OP_GETF;
          2'd1:    tx = (phase == PH_POLL) ? REG_STAT : REG_FEAT;
          default: tx = 8'h00;
        endcase
      end
      PH_FSET, PH_FCLR: begin
        flen = KW'(3);
        case (idx[1:0])
          2'd0:    tx = OP_SETF;
          2'd1:    tx = REG_FEAT;
          default: tx = (phase == PH_FSET) ? (feat | ECC_MASK) : (feat & ~ECC_MASK);
        endcase
      end
      PH_WREN: tx = OP_WREN;
      PH_LOAD: begin
        flen = KW'(3) + KW'(dlen);
        if (idx >= KW'(3)) begin
          tx      = data_in;
          is_data = 1'b1;
        end else begin
          case (idx[1:0])
            2'd0:    tx = OP_LOAD;
            2'd1:    tx = col[15:8];
            default: tx = col[7:0];
          endcase
        end
      end
      PH_EXEC: begin
        flen = KW'(4);
        case (idx[1:0])
          2'd0: tx = OP_EXEC;
          2'd1: tx = row[23:16];
          2'd2: tx = row[15:8];
          default: tx = row[7:0];
        endcase
      end
      PH_ERASE: begin
        flen = KW'(4);
        case (idx[1:0])
          2'd0: tx = OP_ERASE;
          2'd1: tx = 8'h00;
          2'd2: tx = blk[15:8];
          default: tx = blk[7:0];
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/nand_poll_guard.sv
module nand_poll_guard #(
  parameter int PROG_POLL_MAX  = 20000,
  parameter int ERASE_POLL_MAX = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  input  logic is_erase,
  output logic spent
);

  localparam int TOP = (ERASE_POLL_MAX > PROG_POLL_MAX) ? ERASE_POLL_MAX : PROG_POLL_MAX;
  localparam int PW  = $clog2(TOP + 1);

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;

  assign lim   = is_erase ? PW'(ERASE_POLL_MAX) : PW'(PROG_POLL_MAX);
  assign spent = bump && ((cnt + PW'(1)) == lim);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (bump)    cnt <= cnt + PW'(1);
  end

endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq
  import nand_seq_pkg::*;
#(
  parameter int MAX_BYTES      = 4352,
  parameter int PROG_POLL_MAX  = 20000,
  parameter int ERASE_POLL_MAX = 400000,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int KW = $clog2(MAX_BYTES + 4)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_erase,
  input  logic          ecc_en,
  input  logic [23:0]   row_addr,
  input  logic [15:0]   col_addr,
  input  logic [15:0]   blk_addr,
  input  logic [LW-1:0] data_len,
  input  logic [7:0]    data_in,
  output logic          data_next,
  input  logic          err_clr,
  output logic          xfer_req,
  output logic [7:0]    xfer_byte,
  output logic          xfer_last,
  input  logic          xfer_ack,
  input  logic [7:0]    xfer_rx,
  output logic          busy,
  output logic          done,
  output logic          err_prog,
  output logic          err_erase,
  output logic          err_tmo
);

  phase_t        phase;
  logic [KW-1:0] idx;
  logic          wait_ack;
  logic          op_q, ecc_q;
  logic [23:0]   row_q;
  logic [15:0]   col_q, blk_q;
  logic [LW-1:0] len_q;
  logic [7:0]    feat_q, stat_q;

  logic [7:0]    tx_b;
  logic [KW-1:0] flen;
  logic          tx_data;
  logic          ack_fire, ack_end, poll_clr, poll_bump, poll_spent, err_any;

  assign ack_fire  = xfer_ack && wait_ack;
  assign ack_end   = ack_fire && xfer_last;
  assign poll_clr  = ack_end && ((phase == PH_EXEC) || (phase == PH_ERASE));
  assign poll_bump = ack_end && (phase == PH_POLL) && xfer_rx[ST_BUSY];
  assign err_any   = err_prog || err_erase || err_tmo;

  nand_frame_byte #(.KW(KW), .LW(LW)) frame_i (
    .phase(phase), .idx(idx), .row(row_q), .col(col_q), .blk(blk_q),
    .feat(feat_q), .data_in(data_in), .dlen(len_q),
    .tx(tx_b), .flen(flen), .is_data(tx_data)
  );

  nand_poll_guard #(.PROG_POLL_MAX(PROG_POLL_MAX), .ERASE_POLL_MAX(ERASE_POLL_MAX)) guard_i (
    .clk(clk), .rst(rst), .clear(poll_clr), .bump(poll_bump),
    .is_erase(op_q), .spent(poll_spent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;  idx <= '0;  wait_ack <= 1'b0;
      op_q <= 1'b0;  ecc_q <= 1'b0;  row_q <= '0;  col_q <= '0;  blk_q <= '0;
      len_q <= '0;  feat_q <= '0;  stat_q <= '0;
      xfer_req <= 1'b0;  xfer_byte <= '0;  xfer_last <= 1'b0;  data_next <= 1'b0;
      busy <= 1'b0;  done <= 1'b0;
      err_prog <= 1'b0;  err_erase <= 1'b0;  err_tmo <= 1'b0;
    end else begin
      xfer_req  <= 1'b0;
      data_next <= 1'b0;
      done      <= 1'b0;
      if (err_clr) begin
        err_prog <= 1'b0;  err_erase <= 1'b0;  err_tmo <= 1'b0;
      end
      if (phase == PH_IDLE) begin
        if (start && !err_any) begin
          op_q <= op_erase;  ecc_q <= ecc_en;
          row_q <= row_addr;  col_q <= col_addr;  blk_q <= blk_addr;  len_q <= data_len;
          idx <= '0;  busy <= 1'b1;
          phase <= ecc_en ? PH_FRD : PH_WREN;
        end
      end else if (phase == PH_DONE) begin
        if (op_q) err_erase <= stat_q[ST_EFAIL];
        else      err_prog  <= stat_q[ST_PFAIL];
        done  <= 1'b1;
        busy  <= 1'b0;
        phase <= PH_IDLE;
      end else if (ack_fire) begin
        wait_ack <= 1'b0;
        if (!xfer_last) begin
          idx <= idx + KW'(1);
        end else begin
          idx <= '0;
          case (phase)
            PH_FRD:   begin feat_q <= xfer_rx; phase <= PH_FSET; end
            PH_FSET:  phase <= PH_WREN;
            PH_WREN:  phase <= op_q ? PH_ERASE : PH_LOAD;
            PH_LOAD:  phase <= PH_EXEC;
            PH_EXEC,
            PH_ERASE: phase <= PH_POLL;
            PH_POLL: begin
              if (xfer_rx[ST_BUSY]) begin
                if (poll_spent) begin
                  err_tmo <= 1'b1;
                  done    <= 1'b1;
                  busy    <= 1'b0;
                  phase   <= PH_IDLE;
                end
              end else begin
                stat_q <= xfer_rx;
                phase  <= ecc_q ? PH_FRD2 : PH_DONE;
              end
            end
            PH_FRD2:  begin feat_q <= xfer_rx; phase <= PH_FCLR; end
            PH_FCLR:  phase <= PH_DONE;
            default:  phase <= PH_IDLE;
          endcase
        end
      end else if (!wait_ack) begin
        xfer_req  <= 1'b1;
        xfer_byte <= tx_b;
        xfer_last <= (idx == flen - KW'(1));
        data_next <= tx_data;
        wait_ack  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nand_pe_seq_chk.sv
module nand_pe_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic err_clr,
  input logic busy,
  input logic done,
  input logic xfer_req,
  input logic data_next,
  input logic err_prog,
  input logic err_erase,
  input logic err_tmo
);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> !xfer_req); // R11
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !xfer_req); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DATA_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    data_next |-> xfer_req); // R10
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_tmo && !err_clr) |=> err_tmo); // R9
  AST_START_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (err_prog || err_erase || err_tmo)) |=> !busy); // R9
  AST_ONE_ERR_KIND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_prog, err_erase, err_tmo})); // R5

endmodule

bind nand_pe_seq nand_pe_seq_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .err_clr(err_clr), .busy(busy),
  .done(done), .xfer_req(xfer_req), .data_next(data_next),
  .err_prog(err_prog), .err_erase(err_erase), .err_tmo(err_tmo)
);

// File: tb/nand_pe_seq_tb.sv
module nand_pe_seq_tb_top;
  localparam int MAXB = 64;
  localparam int PP   = 4;
  localparam int EP   = 8;
  localparam int LW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start, op_erase, ecc_en, err_clr, xfer_ack;
  logic [23:0] row_addr;
  logic [15:0] col_addr, blk_addr;
  logic [LW-1:0] data_len;
  logic [7:0] data_in, xfer_rx, xfer_byte;
  logic data_next, xfer_req, xfer_last, busy, done, err_prog, err_erase, err_tmo;

  nand_pe_seq #(.MAX_BYTES(MAXB), .PROG_POLL_MAX(PP), .ERASE_POLL_MAX(EP)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_erase(op_erase), .ecc_en(ecc_en),
    .row_addr(row_addr), .col_addr(col_addr), .blk_addr(blk_addr), .data_len(data_len),
    .data_in(data_in), .data_next(data_next), .err_clr(err_clr),
    .xfer_req(xfer_req), .xfer_byte(xfer_byte), .xfer_last(xfer_last),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .busy(busy), .done(done),
    .err_prog(err_prog), .err_erase(err_erase), .err_tmo(err_tmo)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int dn_idx = 0;
  int done_cnt = 0;

  assign data_in = 8'((dn_idx * 37 + 11) & 255);
  always @(posedge clk) begin
    if (data_next) dn_idx <= dn_idx + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Device model
  int logn = 0;
  logic [7:0] log_b [512];
  logic       log_l [512];
  int busy_left = 0;
  logic [7:0] fin_stat = 8'h00;
  logic [7:0] feat_m = 8'h00;

  initial begin
    int pos;
    logic [7:0] b, rx, f_cmd, f_adr;
    pos = 0; f_cmd = 0; f_adr = 0;
    xfer_ack = 1'b0; xfer_rx = 8'h00;
    forever begin
      @(posedge clk); #1;
      if (xfer_req) begin
        b = xfer_byte;
        if (logn < 512) begin log_b[logn] = b; log_l[logn] = xfer_last; end
        logn++;
        rx = 8'h00;
        if (pos == 0) f_cmd = b;
        else if (pos == 1) f_adr = b;
        else if (pos == 2) begin
          if (f_cmd == 8'h0F) begin
            if (f_adr == 8'hC0) begin
              if (busy_left > 0) begin busy_left--; rx = 8'h0D; end
              else rx = fin_stat;
            end else rx = feat_m;
          end else if (f_cmd == 8'h1F) feat_m = b;
        end
        pos = xfer_last ? 0 : pos + 1;
        @(posedge clk); #1;
        xfer_rx = rx; xfer_ack = 1'b1;
        @(posedge clk); #1;
        xfer_ack = 1'b0;
      end
    end
  end

  // Expected stream
  int expn;
  logic [7:0] exp_b [512];
  logic       exp_l [512];

  task automatic push(input logic [7:0] v, input logic l);
    exp_b[expn] = v; exp_l[expn] = l; expn++;
  endtask

  task automatic push3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    push(a, 1'b0); push(b, 1'b0); push(c, 1'b1);
  endtask

  task automatic clr_flags();
    @(posedge clk); #1 err_clr = 1'b1;
    @(posedge clk); #1 err_clr = 1'b0;
  endtask

  task automatic run(input bit er, input bit ecc, input int row, input int col, input int blk,
                     input int len, input int bn, input logic [7:0] fst, input logic [7:0] f0,
                     input bit poke, input string rq);
    int base, dbase, lim, np, t, polls, bad_at;
    bit tmo;
    logic [7:0] v;
    lim = er ? EP : PP;
    tmo = (bn >= lim);
    np = tmo ? lim : bn + 1;
    base = dn_idx; dbase = done_cnt;
    expn = 0;
    v = f0 | 8'h10;
    if (ecc) begin push3(8'h0F, 8'hB0, 8'h00); push3(8'h1F, 8'hB0, v); end
    push(8'h06, 1'b1);
    if (er) begin
      push(8'hD8, 1'b0); push(8'h00, 1'b0); push(8'(blk >> 8), 1'b0); push(8'(blk), 1'b1);
    end else begin
      push(8'h02, 1'b0); push(8'(col >> 8), 1'b0); push(8'(col), len == 0);
      for (int j = 0; j < len; j++) push(8'(((base + j) * 37 + 11) & 255), j == len - 1);
      push(8'h10, 1'b0); push(8'(row >> 16), 1'b0); push(8'(row >> 8), 1'b0); push(8'(row), 1'b1);
    end
    for (int p = 0; p < np; p++) push3(8'h0F, 8'hC0, 8'h00);
    if (ecc && !tmo) begin push3(8'h0F, 8'hB0, 8'h00); push3(8'h1F, 8'hB0, v & 8'hEF); end

    busy_left = bn; fin_stat = fst; feat_m = f0;
    @(posedge clk); #1;
    logn = 0;
    op_erase = er; ecc_en = ecc; row_addr = 24'(row); col_addr = 16'(col);
    blk_addr = 16'(blk); data_len = LW'(len); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    op_erase = ~er; ecc_en = ~ecc; row_addr = 24'h5A5A5A; col_addr = 16'hC3C3;
    blk_addr = 16'h3C3C; data_len = LW'(MAXB);
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    t = 0;
    while (!done && t < 6000) begin
      @(posedge clk); #1; t++;
      if (poke && t == 6) begin
        start = 1'b1; @(posedge clk); #1; start = 1'b0; t++;
      end
    end
    chk(done == 1'b1, "R8 done seen", done, 1);
    chk(busy == 1'b0, "R8 busy low at done", busy, 0);
    repeat (3) @(posedge clk); #1;

    bad_at = -1;
    if (logn != expn) bad_at = 9999;
    else for (int i = 0; i < expn; i++)
      if (bad_at < 0 && (log_b[i] !== exp_b[i] || log_l[i] !== exp_l[i])) bad_at = i;
    if (bad_at >= 0 && bad_at != 9999)
      chk(1'b0, {rq, " byte stream"}, {log_l[bad_at], log_b[bad_at]}, {exp_l[bad_at], exp_b[bad_at]});
    else chk(bad_at < 0, {rq, " byte count"}, logn, expn);

    polls = 0;
    for (int i = 0; i + 1 < logn && i + 1 < 512; i++)
      if ((i == 0 || log_l[i-1]) && log_b[i] == 8'h0F && log_b[i+1] == 8'hC0) polls++;
    chk(polls == np, "R4 poll frames", polls, np);
    chk(done_cnt - dbase == 1, "R8 done pulses", done_cnt - dbase, 1);
    chk(dn_idx - base == (er ? 0 : len), "R10 data_next count", dn_idx - base, er ? 0 : len);
    chk(err_prog == (!er && !tmo && fst[3]), "R5 err_prog", err_prog, !er && !tmo && fst[3]);
    chk(err_erase == (er && !tmo && fst[2]), "R5 err_erase", err_erase, er && !tmo && fst[2]);
    chk(err_tmo == tmo, "R6 err_tmo", err_tmo, tmo);
    if (ecc && !tmo) chk(feat_m == (f0 & 8'hEF), "R7 feature restored", feat_m, f0 & 8'hEF);
    if (ecc && tmo)  chk(feat_m == v, "R6 feature left set", feat_m, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lens [5];
    int L;
    lens = '{0, 1, 2, 7, 16};
    rst = 1'b1; start = 1'b0; op_erase = 1'b0; ecc_en = 1'b0; err_clr = 1'b0;
    row_addr = '0; col_addr = '0; blk_addr = '0; data_len = '0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    chk(busy == 0 && done == 0 && xfer_req == 0 && data_next == 0, "R1 idle outputs",
        {busy, done, xfer_req, data_next}, 0);
    chk(err_prog == 0 && err_erase == 0 && err_tmo == 0, "R1 error flags",
        {err_prog, err_erase, err_tmo}, 0);

    // R2 program sweep over lengths, busy replies and ECC select
    for (int li = 0; li < 5; li++)
      for (int bn = 0; bn < 4; bn += (bn == 1) ? 2 : 1)
        for (int e = 0; e < 2; e++)
          run(1'b0, e[0], 24'h01_0203 * (li + 1), 16'h0100 + li * 16'h0111, 0, lens[li],
              bn, 8'h00, 8'h06 + 8'(li), 1'b0, "R2");

    // R3 erase sweep, including the last poll before the budget
    for (int k = 0; k < 3; k++)
      for (int bn = 0; bn < 8; bn += 7)
        for (int e = 0; e < 2; e++)
          run(1'b1, e[0], 0, 0, (k == 0) ? 0 : (k == 1) ? 16'hA55A : 16'hFFFF,
              0, bn, 8'h00, 8'h1F, 1'b0, "R3");

    // R7 feature bit 4 already set before the operation
    run(1'b0, 1'b1, 24'hABCDEF, 16'h0FFF, 0, 3, 1, 8'h00, 8'h5A, 1'b0, "R7");

    // R9 start during an operation is ignored
    run(1'b0, 1'b0, 24'h123456, 16'h0042, 0, 5, 2, 8'h00, 8'h00, 1'b1, "R9");

    // R5 program fail, then refusal while flagged
    run(1'b0, 1'b0, 24'h000777, 16'h0010, 0, 2, 1, 8'h08, 8'h00, 1'b0, "R5");
    L = logn;
    @(posedge clk); #1 start = 1'b1; op_erase = 1'b0;
    @(posedge clk); #1 start = 1'b0;
    repeat (10) @(posedge clk); #1;
    chk(busy == 1'b0, "R9 start refused while flagged", busy, 0);
    chk(logn == L, "R9 no frames while flagged", logn, L);
    chk(err_prog == 1'b1, "R9 flag holds", err_prog, 1);
    clr_flags();
    #1 chk({err_prog, err_erase, err_tmo} == 3'b000, "R9 err_clr", {err_prog, err_erase, err_tmo}, 0);

    run(1'b0, 1'b0, 24'h000778, 16'h0020, 0, 1, 0, 8'h04, 8'h00, 1'b0, "R5");
    run(1'b1, 1'b0, 0, 0, 16'h0321, 0, 2, 8'h04, 8'h00, 1'b0, "R5");
    clr_flags();
    run(1'b1, 1'b0, 0, 0, 16'h0322, 0, 0, 8'h08, 8'h00, 1'b0, "R5");

    // R6 timeouts on both budgets
    run(1'b0, 1'b1, 24'h00F00D, 16'h0003, 0, 4, 100, 8'h00, 8'h02, 1'b0, "R6");
    clr_flags();
    run(1'b1, 1'b0, 0, 0, 16'h0BAD, 0, 100, 8'h00, 8'h00, 1'b0, "R6");
    clr_flags();
    run(1'b0, 1'b0, 24'h000001, 16'h0000, 0, 2, PP, 8'h00, 8'h00, 1'b0, "R6");
    clr_flags();
    #1 chk(err_tmo == 1'b0, "R9 err_clr after timeout", err_tmo, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule